// File: doc/BRIEF.md
# Byte-Writable Memory with Incremental Word Parity

This block is a storage array of 64-bit words, each guarded by a single parity bit. Writes carry one enable per byte, so any subset of a word's eight bytes can be replaced in one cycle. The parity bit covers the whole word, yet a partial write never fetches the bytes it leaves alone. It takes the parity of the bytes being replaced (old values), the parity of their new values and the stored parity bit, and combines the three with XOR. Only the lanes being overwritten are consulted. Reads use their own port, so a write can be accepted every cycle with no stall, next to an independent read.

Reads are synchronous. Each returned word comes with an error flag that is set when the word and its stored parity disagree. The scheme detects errors and does not correct them: an odd number of flipped bits is reported, while an even number goes unseen. An injection input flips one chosen stored data bit and leaves the parity alone, so the detection path can be exercised.

Top module: `parmem_top`

## Requirements
- R1: After reset every word reads as zero with the error flag clear.
- R2: A read requested at a clock edge presents rdValid, rdData and rdErr after that edge, one cycle later. The value returned is the one stored before that edge, so a write to the same address at the same edge is not yet visible.
- R3: Enable bit i of wrByteEn selects data bits [8i+7:8i]. A write changes only the enabled bytes, and every other byte of the word keeps its value.
- R4: A write with all eight enables set stores parity equal to the XOR of the 64 new data bits.
- R5: A partial write stores parity equal to the old parity XOR the parity of the new enabled bytes XOR the parity of the old enabled bytes. A word's error status is therefore the same after such a write as before it.
- R6: A write with no byte enable set changes neither data nor parity of any word.
- R7: rdErr equals the XOR of the 64 returned data bits and the stored parity bit, and it appears in the same cycle as the data. Two flipped bits in one word are not flagged.
- R8: An inject request flips bit injBit of word injAddr, where bit index b lies in byte b/8 at position b%8, and leaves the parity unchanged. The next read of that word flags an error, and a second flip of the same bit clears it.
- R9: When an inject and a write name the same address in one cycle, the write is applied first and the chosen bit of the result is then flipped.
- R10: Writes are accepted on every cycle back to back, alongside a read every cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrAddr | input | 8 | Write word address |
| wrByteEn | input | 8 | Per-byte write enables |
| wrData | input | 64 | Write data |
| rdEn | input | 1 | Read request |
| rdAddr | input | 8 | Read word address |
| rdValid | output | 1 | Read result valid |
| rdData | output | 64 | Read data |
| rdErr | output | 1 | Parity mismatch on the returned word |
| injEn | input | 1 | Inject request |
| injAddr | input | 8 | Word to corrupt |
| injBit | input | 6 | Bit index to flip |

## Verification
A wrong parity update does not show up at the write. It shows up only when that word is read back, as rdErr set on clean data or cleared on corrupted data, one cycle after the read request. A write that disturbs an untouched lane shows up as wrong rdData on the next read of that word. The bench therefore keeps a behavioural copy of every word and its parity bit and compares each read result on the cycle it appears. Reads come straight after writes, partial writes land on words already carrying injected errors, and an inject is issued in the same cycle as a write to the same word.

// File: rtl/parmem_pkg.sv
package parmem_pkg;
  typedef struct packed {
    logic doWrite;   // a write with at least one enabled byte
    logic fullWrite; // all bytes enabled
    logic doInject;  // flip one stored bit
    logic doRead;    // capture a read
  } memStrobe_t;
endpackage

// File: rtl/parmem_ctrl.sv
module parmem_ctrl
  import parmem_pkg::*;
#(
  parameter int BYTES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [BYTES-1:0] wrByteEn,
  input  logic             rdEn,
  input  logic             injEn,
  output memStrobe_t       strobe,
  output logic [BYTES-1:0] laneWe,
  output logic             rdValid
);
  always_comb begin
    laneWe           = wrEn ? wrByteEn : '0;
    strobe.doWrite   = |laneWe;
    strobe.fullWrite = &laneWe;
    strobe.doInject  = injEn;
    strobe.doRead    = rdEn;
  end

  always_ff @(posedge clk) begin
    if (rst) rdValid <= 1'b0;
    else     rdValid <= rdEn;
  end

  // R2: a read result follows its request by exactly one cycle
  a_r2_read_valid: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> rdValid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> !rdValid);
endmodule

// File: rtl/parmem_store.sv
module parmem_store
  import parmem_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int BYTES  = 8,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int DATA_W = 8 * BYTES,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  memStrobe_t        strobe,
  input  logic [BYTES-1:0]  laneWe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [BIT_W-1:0]  injBit,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr
);
  localparam int BYTE_W = 8;
  localparam int LANE_W = $clog2(BYTES);

  logic [DATA_W-1:0] oldMasked;   // old values of enabled lanes only
  logic [DATA_W-1:0] wrMask;
  logic [DATA_W-1:0] rdWordNow;
  logic [DATA_W-1:0] preWordW, preWordI, postWordW, postWordI; // check probes
  logic              parMem [DEPTH];
  logic              newPar;
  logic [DATA_W-1:0] rdDataQ;
  logic              rdParQ;

  // check-side history
  logic [ADDR_W-1:0] lastWrAddr, lastInjAddr;
  logic              lastFull, lastPartial, lastInjOnly, lastPreErrW, lastPreErrI;
  logic              injSameWr;

  assign injSameWr = strobe.doInject && strobe.doWrite && (injAddr == wrAddr);

  for (genvar g = 0; g < BYTES; g++) begin : gLane
    logic [BYTE_W-1:0] laneMem [DEPTH];
    logic [BYTE_W-1:0] newByte, oldByte, injVal;
    logic              injHit;
    logic              keepNow, lastKeep;
    logic [BYTE_W-1:0] lastByte;

    assign newByte = wrData[BYTE_W*g +: BYTE_W];
    // only an enabled lane is looked at for the parity delta
    assign oldByte = laneWe[g] ? laneMem[wrAddr] : '0;
    assign injHit  = strobe.doInject && (injBit[BIT_W-1:BIT_W-LANE_W] == LANE_W'(g));
    assign injVal  = ((laneWe[g] && (injAddr == wrAddr)) ? newByte : laneMem[injAddr])
                     ^ (BYTE_W'(1) << injBit[BIT_W-LANE_W-1:0]);

    assign oldMasked[BYTE_W*g +: BYTE_W] = oldByte;
    assign wrMask[BYTE_W*g +: BYTE_W]    = {BYTE_W{laneWe[g]}};
    assign rdWordNow[BYTE_W*g +: BYTE_W] = laneMem[rdAddr];
    assign preWordW[BYTE_W*g +: BYTE_W]  = laneMem[wrAddr];
    assign preWordI[BYTE_W*g +: BYTE_W]  = laneMem[injAddr];
    assign postWordW[BYTE_W*g +: BYTE_W] = laneMem[lastWrAddr];
    assign postWordI[BYTE_W*g +: BYTE_W] = laneMem[lastInjAddr];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
      end else begin
        if (laneWe[g]) laneMem[wrAddr] <= newByte;
        if (injHit)    laneMem[injAddr] <= injVal; // R9: flip lands after the write
      end
    end

    assign keepNow = strobe.doWrite && !laneWe[g] && !(injHit && (injAddr == wrAddr));

    always_ff @(posedge clk) begin
      if (rst) begin
        lastKeep <= 1'b0;
        lastByte <= '0;
      end else begin
        lastKeep <= keepNow;
        lastByte <= laneMem[wrAddr];
      end
    end

    // R3: a lane without its enable keeps its byte through a write
    a_r3_untouched_lane: assert property (@(posedge clk) disable iff (rst)
      lastKeep |-> laneMem[lastWrAddr] == lastByte);
  end

  // incremental parity: stored bit, new enabled bytes, old enabled bytes
  assign newPar = strobe.fullWrite ? ^wrData
                : parMem[wrAddr] ^ (^(wrData & wrMask)) ^ (^oldMasked);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) parMem[i] <= 1'b0;
    end else if (strobe.doWrite) begin
      parMem[wrAddr] <= newPar;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdDataQ <= '0;
      rdParQ  <= 1'b0;
    end else if (strobe.doRead) begin
      rdDataQ <= rdWordNow;
      rdParQ  <= parMem[rdAddr];
    end
  end

  assign rdData = rdDataQ;
  assign rdErr  = (^rdDataQ) ^ rdParQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      lastWrAddr  <= '0;
      lastInjAddr <= '0;
      lastFull    <= 1'b0;
      lastPartial <= 1'b0;
      lastInjOnly <= 1'b0;
      lastPreErrW <= 1'b0;
      lastPreErrI <= 1'b0;
    end else begin
      lastWrAddr  <= wrAddr;
      lastInjAddr <= injAddr;
      lastFull    <= strobe.fullWrite && !injSameWr;
      lastPartial <= strobe.doWrite && !strobe.fullWrite && !injSameWr;
      lastInjOnly <= strobe.doInject && !(strobe.doWrite && (injAddr == wrAddr));
      lastPreErrW <= (^preWordW) ^ parMem[wrAddr];
      lastPreErrI <= (^preWordI) ^ parMem[injAddr];
    end
  end

  // R4: a full-word write leaves the word consistent with its parity
  a_r4_full_even: assert property (@(posedge clk) disable iff (rst)
    lastFull |-> (((^postWordW) ^ parMem[lastWrAddr]) == 1'b0));
  // R5: a partial write preserves the word's error status
  a_r5_status_kept: assert property (@(posedge clk) disable iff (rst)
    lastPartial |-> (((^postWordW) ^ parMem[lastWrAddr]) == lastPreErrW));
  // R8: an inject toggles the word's error status
  a_r8_inject_toggles: assert property (@(posedge clk) disable iff (rst)
    lastInjOnly |-> (((^postWordI) ^ parMem[lastInjAddr]) != lastPreErrI));
endmodule

// File: rtl/parmem_top.sv
module parmem_top
  import parmem_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int BYTES  = 8,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int DATA_W = 8 * BYTES,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTES-1:0]  wrByteEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [BIT_W-1:0]  injBit
);
  memStrobe_t       strobe;
  logic [BYTES-1:0] laneWe;

  parmem_ctrl #(.BYTES(BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrByteEn(wrByteEn), .rdEn(rdEn),
    .injEn(injEn), .strobe(strobe), .laneWe(laneWe), .rdValid(rdValid)
  );

  parmem_store #(
    .DEPTH(DEPTH), .BYTES(BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)
  ) u_store (
    .clk(clk), .rst(rst), .strobe(strobe), .laneWe(laneWe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .injAddr(injAddr), .injBit(injBit),
    .rdData(rdData), .rdErr(rdErr)
  );
endmodule

// File: tb/test_parmem_top.sv
module test_parmem_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [7:0]  wrByteEn = '0;
  logic [63:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic        rdValid;
  logic [63:0] rdData;
  logic        rdErr;
  logic        injEn = 1'b0;
  logic [7:0]  injAddr = '0;
  logic [5:0]  injBit = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [63:0] refMem [256];
  bit          refPar [256];

  always #5 clk = ~clk;

  parmem_top i_parmem_top (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrByteEn(wrByteEn),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .rdErr(rdErr), .injEn(injEn), .injAddr(injAddr), .injBit(injBit)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, advance the model at the edge, compare after it
  task automatic step(input bit we, input [7:0] wa, input [7:0] be, input [63:0] wd,
                      input bit re, input [7:0] ra,
                      input bit ie, input [7:0] ia, input [5:0] ib, input string tag);
    logic [63:0] expData, mask, oldW, newW;
    bit expErr;
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrByteEn = be; wrData = wd;
    rdEn = re; rdAddr = ra; injEn = ie; injAddr = ia; injBit = ib;
    expData = refMem[ra];
    expErr  = (^refMem[ra]) ^ refPar[ra];
    @(posedge clk);
    if (we && be != 8'h00) begin
      mask = '0;
      for (int b = 0; b < 8; b++) if (be[b]) mask[8*b +: 8] = 8'hFF;
      oldW = refMem[wa];
      newW = (oldW & ~mask) | (wd & mask);
      if (be == 8'hFF) refPar[wa] = ^newW;
      else refPar[wa] = refPar[wa] ^ (^(wd & mask)) ^ (^(oldW & mask));
      refMem[wa] = newW;
    end
    if (ie) refMem[ia][ib] = ~refMem[ia][ib];
    #2;
    check(tag, "rdValid", 64'(rdValid), 64'(re));
    if (re) begin
      check(tag, "rdData", rdData, expData);
      check(tag, "rdErr", 64'(rdErr), 64'(expErr));
    end
  endtask

  task automatic rd(input [7:0] a, input string tag);
    step(0, 0, 0, 0, 1, a, 0, 0, 0, tag);
  endtask

  task automatic wr(input [7:0] a, input [7:0] be, input [63:0] d, input string tag);
    step(1, a, be, d, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic inj(input [7:0] a, input [5:0] b, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, a, b, tag);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin refMem[i] = '0; refPar[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset contents
    rd(8'd0, "R1"); rd(8'd255, "R1"); rd(8'd77, "R1");

    // R4 / R7: full-word writes, parity from data
    wr(8'd1, 8'hFF, 64'h0123_4567_89AB_CDEF, "R4");
    wr(8'd2, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    wr(8'd3, 8'hFF, 64'h8000_0000_0000_0001, "R4");
    rd(8'd1, "R4"); rd(8'd2, "R7"); rd(8'd3, "R4");

    // R3 / R5: partial writes touch only enabled bytes
    wr(8'd1, 8'h01, 64'hAAAA_AAAA_AAAA_AA7F, "R3");
    rd(8'd1, "R3");
    wr(8'd1, 8'h5A, 64'h1122_3344_5566_7788, "R5");
    rd(8'd1, "R5");
    wr(8'd2, 8'h80, 64'h0100_0000_0000_0000, "R5");
    rd(8'd2, "R5");

    // R6: no enables, no change
    wr(8'd1, 8'h00, 64'hDEAD_BEEF_DEAD_BEEF, "R6");
    rd(8'd1, "R6");

    // R2: read and write to the same word at one edge return the old value
    step(1, 8'd3, 8'hFF, 64'h0000_0000_0000_0007, 1, 8'd3, 0, 0, 0, "R2");
    rd(8'd3, "R2");

    // R8: inject sets the flag, second flip clears it
    inj(8'd1, 6'd0, "R8");
    rd(8'd1, "R8");
    wr(8'd1, 8'h10, 64'h0000_00FF_0000_0000, "R5");
    rd(8'd1, "R5");
    inj(8'd1, 6'd0, "R8");
    rd(8'd1, "R8");
    // R7: two flips in one word go unseen
    inj(8'd3, 6'd63, "R7");
    inj(8'd3, 6'd62, "R7");
    rd(8'd3, "R7");

    // R9: inject and write on the same word in one cycle
    step(1, 8'd4, 8'hFF, 64'h0F0F_0F0F_0F0F_0F0F, 0, 0, 1, 8'd4, 6'd10, "R9");
    rd(8'd4, "R9");
    step(1, 8'd5, 8'h02, 64'h0000_0000_0000_3C00, 0, 0, 1, 8'd5, 6'd9, "R9");
    rd(8'd5, "R9");

    // R10: back-to-back writes with a read every cycle
    for (int n = 0; n < 400; n++) begin
      bit doInj;
      doInj = ($urandom % 16) == 0;
      step(1, 8'($urandom % 16), 8'($urandom), {$urandom, $urandom},
           1, 8'($urandom % 16), doInj, 8'($urandom % 16), 6'($urandom), "R10");
    end
    for (int a = 0; a < 16; a++) rd(8'(a), "R10");

    summary();
  end
endmodule